// File: doc/BRIEF.md
# Write-Per-Bit Masked Write Front-End

This block sits between the asynchronous, active-low strobe pins of a 16-bit video memory and a small internal word array. It oversamples the row strobe, the two byte-lane column strobes and the write-enable with a fast system clock. From their edges it works out whether the current row cycle writes through a per-bit mask. It then captures the mask, the row and column addresses and the write data at the right moments. Finally it commits a single read-modify-write to the array.

When write-enable is low as the row strobe falls, the word on the data pins at that moment becomes the bit mask for this cycle only. When write-enable is high at that edge, every bit is enabled. The data is taken at the later of two events: the first column-strobe fall or the write-enable fall. Each column strobe opens one byte lane, and that lane is still filtered by the mask. If the row strobe returns high before any data has been taken, the cycle writes nothing.

Top module: `wpb_write_front`

## Requirements
- R1: After reset no write is issued and every array word reads 0.
- R2: If we_ni is high when ras_ni falls, the cycle is unmasked and all 16 bits of each opened lane are enabled.
- R3: If we_ni is low when ras_ni falls, dq_i at that edge is the mask: a 1 at bit k lets data bit k be written, and a 0 leaves stored bit k unchanged.
- R4: The mask lasts for one row cycle only. A later unmasked cycle writes every bit of its opened lanes, whatever mask came before.
- R5: Early write: when we_ni is already low at the first column-strobe fall, dq_i is captured at that column-strobe fall.
- R6: Late write: when we_ni falls after the column strobe, dq_i is captured at the we_ni fall.
- R7: casl_ni low at capture opens bits 7:0, and casu_ni low opens bits 15:8. wr_be_o equals the mask ANDed with the opened lanes.
- R8: At most one write is committed per row cycle, to address {row, column}. The row comes from addr_i at the ras_ni fall and the column from addr_i at the first column-strobe fall.
- R9: If ras_ni rises before data is captured, nothing is written and the array is unchanged.
- R10: wr_en_o is a single-cycle pulse, and it only occurs while the synchronized ras_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| casl_ni | input | 1 | Lower-byte column strobe, active low |
| casu_ni | input | 1 | Upper-byte column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| dq_i | input | 16 | Data pins: mask at row fall, data at capture |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| rd_addr_i | input | 2*ADDR_W | Array read address {row, column} |
| rd_data_o | output | 16 | Array word at rd_addr_i |
| wr_en_o | output | 1 | Write commit pulse |
| wr_addr_o | output | 2*ADDR_W | Committed address {row, column} |
| wr_data_o | output | 16 | Committed data |
| wr_be_o | output | 16 | Effective bit enables |

## Verification
The sweep crosses three things: masked and unmasked cycles, early and late write-enable timing, and all four lane combinations, with mask and data words derived arithmetically. Comparing masked with unmasked cycles separates the R2 and R3 paths. Comparing early with late timing shows which edge captures the data, because dq_i carries a different value before each event. The no-lane cycles and an explicit abort, where the column strobe fell but write-enable never did, separate discard from commit. A masked-then-unmasked pair on one address confirms that the mask does not carry over into the next cycle.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned WORD_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROW,
    ST_COMMIT,
    ST_DRAIN
  } wpb_state_e;
endpackage

// File: rtl/wpb_strobe_sync.sv
module wpb_strobe_sync #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strobe_ni,
  output logic [N-1:0] level_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s0_q, s1_q, s2_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s0_q[g] <= 1'b1;
        s1_q[g] <= 1'b1;
        s2_q[g] <= 1'b1;
      end else begin
        s0_q[g] <= strobe_ni[g];
        s1_q[g] <= s0_q[g];
        s2_q[g] <= s1_q[g];
      end
    end
    assign level_o[g] = s1_q[g];
    assign fall_o[g]  = s2_q[g] & ~s1_q[g];
  end
endmodule

// File: rtl/wpb_ctrl.sv
module wpb_ctrl
  import wpb_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned WA_W  = 2 * ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_lvl_i,
  input  logic              ras_fall_i,
  input  logic [LANES-1:0]  cas_lvl_i,
  input  logic              we_lvl_i,
  input  logic [WORD_W-1:0] dq_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_en_o,
  output logic [WA_W-1:0]   wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic [WORD_W-1:0] wr_be_o,
  output logic              masked_o,
  output wpb_state_e        state_o
);
  wpb_state_e        state_q;
  logic              masked_q, col_seen_q, wr_en_q;
  logic [WORD_W-1:0] mask_q, data_q, lane_be;
  logic [LANES-1:0]  lane_q;
  logic [ADDR_W-1:0] row_q, col_q;
  logic              cas_any_low;

  assign cas_any_low = ~&cas_lvl_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_be[g*LANE_W +: LANE_W] = {LANE_W{lane_q[g]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      masked_q   <= 1'b0;
      col_seen_q <= 1'b0;
      wr_en_q    <= 1'b0;
      mask_q     <= '0;
      data_q     <= '0;
      lane_q     <= '0;
      row_q      <= '0;
      col_q      <= '0;
    end else begin
      wr_en_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ras_fall_i) begin
            masked_q   <= ~we_lvl_i;
            mask_q     <= we_lvl_i ? '1 : dq_i;  // fresh mask each row cycle
            row_q      <= addr_i;
            col_seen_q <= 1'b0;
            state_q    <= ST_ROW;
          end
        end
        ST_ROW: begin
          if (ras_lvl_i) begin
            state_q <= ST_IDLE;  // row closed before data: discard
          end else begin
            if (cas_any_low && !col_seen_q) begin
              col_q      <= addr_i;
              col_seen_q <= 1'b1;
            end
            // first cycle with both CAS and WE low = later of the two falls
            if (cas_any_low && !we_lvl_i) begin
              data_q  <= dq_i;
              lane_q  <= ~cas_lvl_i;
              state_q <= ST_COMMIT;
            end
          end
        end
        ST_COMMIT: begin
          wr_en_q <= 1'b1;
          state_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (ras_lvl_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = {row_q, col_q};
  assign wr_data_o = data_q;
  assign wr_be_o   = mask_q & lane_be;
  assign masked_o  = masked_q;
  assign state_o   = state_q;
endmodule

// File: rtl/wpb_word_array.sv
module wpb_word_array #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AW     = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] wbe_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= (mem_q[waddr_i] & ~wbe_i) | (wdata_i & wbe_i);
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/wpb_write_front.sv
module wpb_write_front
  import wpb_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned WA_W  = 2 * ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              casl_ni,
  input  logic              casu_ni,
  input  logic              we_ni,
  input  logic [WORD_W-1:0] dq_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WA_W-1:0]   rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              wr_en_o,
  output logic [WA_W-1:0]   wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic [WORD_W-1:0] wr_be_o
);
  localparam int unsigned NSTB = LANES + 2;

  logic [NSTB-1:0] stb_lvl, stb_fall;
  logic            ras_lvl, masked_q;
  wpb_state_e      state;

  wpb_strobe_sync #(.N(NSTB)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_ni({we_ni, casu_ni, casl_ni, ras_ni}),
    .level_o  (stb_lvl),
    .fall_o   (stb_fall)
  );

  assign ras_lvl = stb_lvl[0];

  wpb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ras_lvl_i (ras_lvl),
    .ras_fall_i(stb_fall[0]),
    .cas_lvl_i (stb_lvl[LANES:1]),
    .we_lvl_i  (stb_lvl[NSTB-1]),
    .dq_i      (dq_i),
    .addr_i    (addr_i),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .wr_be_o   (wr_be_o),
    .masked_o  (masked_q),
    .state_o   (state)
  );

  wpb_word_array #(.DATA_W(WORD_W), .AW(WA_W)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_o),
    .waddr_i(wr_addr_o),
    .wdata_i(wr_data_o),
    .wbe_i  (wr_be_o),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/wpb_write_front_chk.sv
module wpb_write_front_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ras_lvl_i,
  input logic        wr_en_i,
  input logic        masked_i,
  input logic [15:0] be_i
);
  logic [1:0] writes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        writes_q <= '0;
    else if (ras_lvl_i) writes_q <= '0;
    else if (wr_en_i && writes_q != 2'd3) writes_q <= writes_q + 2'd1;
  end

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !wr_en_i);

  a_r10_ras_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !ras_lvl_i && $past(!ras_lvl_i));

  a_r8_one_per_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> writes_q == 2'd0);

  a_r2_full_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !masked_i) |->
      ((be_i[7:0] == 8'h00) || (be_i[7:0] == 8'hFF)) &&
      ((be_i[15:8] == 8'h00) || (be_i[15:8] == 8'hFF)));
endmodule

bind wpb_write_front wpb_write_front_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ras_lvl_i(ras_lvl),
  .wr_en_i  (wr_en_o),
  .masked_i (masked_q),
  .be_i     (wr_be_o)
);

// File: tb/wpb_write_front_test.sv
module wpb_write_front_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ras_ni = 1'b1, casl_ni = 1'b1, casu_ni = 1'b1, we_ni = 1'b1;
  logic [15:0] dq_i = '0;
  logic [3:0]  addr_i = '0;
  logic [7:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o, wr_data_o, wr_be_o;
  logic        wr_en_o;
  logic [7:0]  wr_addr_o;

  int unsigned n_run = 0, n_fail = 0, n_wr = 0;
  logic [15:0] last_be;
  logic [7:0]  last_addr;
  logic [15:0] ref_mem [256];

  always #4 clk = ~clk;

  wpb_write_front uut (
    .clk_i(clk), .rst_ni(rst_ni), .ras_ni(ras_ni), .casl_ni(casl_ni),
    .casu_ni(casu_ni), .we_ni(we_ni), .dq_i(dq_i), .addr_i(addr_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_be_o(wr_be_o)
  );

  always @(negedge clk) if (rst_ni && wr_en_o) begin
    n_wr++;
    last_be   = wr_be_o;
    last_addr = wr_addr_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_chk(input string req, input logic [7:0] a);
    rd_addr_i = a;
    wait_n(1);
    chk(req, rd_data_o, ref_mem[a]);
  endtask

  // one row cycle; lanes[0]=CASL, lanes[1]=CASU; no_we: WE never falls
  task automatic ras_cycle(input logic [3:0] row, input logic [3:0] col,
                           input bit masked, input logic [15:0] mask,
                           input logic [15:0] data, input logic [1:0] lanes,
                           input bit late, input bit no_we, input string req);
    logic [15:0] be;
    bit          commit;
    n_wr = 0;
    addr_i = row;
    we_ni  = !masked;
    dq_i   = masked ? mask : 16'hDEAD;
    wait_n(6);
    ras_ni = 1'b0;
    wait_n(6);
    if (late || no_we) we_ni = 1'b1;
    dq_i = late ? 16'hBEEF : data;  // late: pins hold junk at CAS fall
    wait_n(6);
    if (!late && !no_we) we_ni = 1'b0;
    addr_i  = col;
    casl_ni = !lanes[0];
    casu_ni = !lanes[1];
    wait_n(6);
    if (late && !no_we) begin
      dq_i  = data;
      we_ni = 1'b0;
      wait_n(6);
    end
    ras_ni = 1'b1; casl_ni = 1'b1; casu_ni = 1'b1; we_ni = 1'b1;
    dq_i = '0;
    wait_n(8);
    commit = (lanes != 2'b00) && !no_we;
    be = (masked ? mask : 16'hFFFF) & {{8{lanes[1]}}, {8{lanes[0]}}};
    if (commit)
      ref_mem[{row, col}] = (ref_mem[{row, col}] & ~be) | (data & be);
    chk({req, " R8 write count"}, n_wr, commit ? 1 : 0);
    if (commit) begin
      chk({req, " R7 bit enables"}, last_be, be);
      chk({req, " R8 address"}, last_addr, {row, col});
    end
    read_chk({req, " array word"}, {row, col});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = '0;
    wait_n(3);
    chk("R1 no write in reset", wr_en_o, 1'b0);
    rst_ni = 1'b1;
    wait_n(4);
    chk("R1 no write after reset", n_wr, 0);
    for (int a = 0; a < 256; a += 37) read_chk("R1 array cleared", a[7:0]);

    // R2/R3/R5/R6/R7/R9 sweep: masked x late x lanes, arithmetic words
    for (int i = 0; i < 64; i++) begin
      logic [15:0] m, d;
      m = 16'(i * 40503) ^ 16'h5A5A;
      d = 16'(i * 15133) + 16'h1234;
      ras_cycle(4'(i), 4'(i * 7 + 3), i[2], m, d, i[1:0], i[3], 1'b0,
                i[2] ? (i[3] ? "R3 R6 masked late" : "R3 R5 masked early")
                     : (i[3] ? "R2 R6 unmasked late" : "R2 R5 unmasked early"));
    end

    // R4: masked cycle then unmasked cycle on the same word
    ras_cycle(4'hA, 4'h5, 1'b1, 16'h0F0F, 16'hFFFF, 2'b11, 1'b0, 1'b0, "R4 masked");
    ras_cycle(4'hA, 4'h5, 1'b0, 16'h0000, 16'h1234, 2'b11, 1'b1, 1'b0, "R4 unmasked after mask");
    chk("R4 full word written", rd_data_o, 16'h1234);

    // R3: zero mask leaves word unchanged
    ras_cycle(4'hA, 4'h5, 1'b1, 16'h0000, 16'hFFFF, 2'b11, 1'b0, 1'b0, "R3 zero mask");
    chk("R3 zero mask keeps word", rd_data_o, 16'h1234);

    // R9: CAS fell, WE never did, row closes -> no write
    ras_cycle(4'hA, 4'h5, 1'b0, 16'h0000, 16'h9999, 2'b11, 1'b1, 1'b1, "R9 abort");
    chk("R9 word unchanged", rd_data_o, 16'h1234);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule